// File: doc/BRIEF.md
# Read-Only Port to I/O Bus Bridge

This bridge lets a host that can only issue read cycles on a cartridge ROM port drive an 8-bit (optionally 16-bit) ISA-style I/O bus. Each host cycle is decoded by its address into one of two windows. In the lower window (side A) the cycle becomes an I/O read, and the peripheral data is returned on the host data bus. In the upper window (side B, address bit 16 set) the cycle becomes an I/O write. Because the host cannot drive data during a read, the write byte travels on host address bits 8..1.

Wide peripherals are written in two steps. An access to a load sub-window of side A (address bit 15 set) stores a low byte from address bits 8..1 in a holding latch and sets its valid flag. A wide access in side B then supplies the high byte, issues one 16-bit I/O write and clears the flag. Wide reads return the full peripheral word in a single host access.

Every I/O transfer runs through the same sequence. One setup cycle with the address stable comes first. The strobe then stays high for a programmed length. One hold cycle follows, and after it an acknowledge that stays up until the host drops its select.

Top module: `rom_isa_bridge`

## Requirements
- R1: After reset, isa_ior_o, isa_iow_o, rom_ack_o, rom_data_oe_o and isa_data_oe_o are all 0.
- R2: During a transfer, isa_addr_o equals 0x300 with bits 4..0 taken from host address bits 13..9.
- R3: A narrow side-A access (bit16=0, bit15=0, rom_wide_i=0) performs one I/O read. The peripheral byte isa_data_i[7:0] is returned on rom_data_o[15:8], and rom_data_o[7:0] is 0.
- R4: A wide side-A access (bit16=0, bit15=0, rom_wide_i=1) performs one 16-bit I/O read with isa_wide_o=1 and returns isa_data_i[15:0] on rom_data_o.
- R5: A narrow side-B access (bit16=1, rom_wide_i=0) performs one I/O write. isa_data_o[7:0] carries host address bits 8..1, isa_data_o[15:8] is 0 and isa_wide_o is 0. The holding latch is left unchanged.
- R6: A side-A access with bit15=1 issues no I/O strobe. It loads host address bits 8..1 into the holding latch, sets the valid flag and overwrites any pending byte.
- R7: A wide side-B access while the latch is valid performs one 16-bit write of {address bits 8..1, latched byte} with isa_wide_o=1, then clears the valid flag.
- R8: A wide side-B access while the latch is not valid issues no I/O strobe and is still acknowledged.
- R9: An I/O transfer has one setup cycle, then a strobe of max(strobe_len_i,1) cycles, then one hold cycle. rom_ack_o rises L+3 cycles after select is seen (1 cycle for cycles without a strobe) and stays high until rom_sel_i falls.
- R10: rom_data_oe_o is high only while a read is acknowledged. isa_data_oe_o is high only during the setup, strobe and hold of a write.
- R11: With rom_sel_i low no strobe or acknowledge occurs, and isa_ior_o and isa_iow_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rom_sel_i | input | 1 | Host ROM-port select, active high |
| rom_addr_i | input | 17 | Host byte address (bit 16 window side, bit 15 load sub-window) |
| rom_wide_i | input | 1 | Host access is 16 bits wide |
| strobe_len_i | input | 4 | Strobe length in cycles, 0 treated as 1 |
| rom_data_o | output | 16 | Read data to host, 0 when not driven |
| rom_data_oe_o | output | 1 | Host data bus drive enable |
| rom_ack_o | output | 1 | Cycle complete |
| isa_addr_o | output | 10 | I/O bus address |
| isa_data_o | output | 16 | I/O write data |
| isa_data_i | input | 16 | I/O read data |
| isa_data_oe_o | output | 1 | I/O data bus drive enable |
| isa_wide_o | output | 1 | Transfer is 16 bits wide |
| isa_ior_o | output | 1 | I/O read strobe, active high |
| isa_iow_o | output | 1 | I/O write strobe, active high |

## Verification
The assertions assume the host holds rom_sel_i, the address, the width and the strobe length steady from the cycle select rises until it sees rom_ack_o, and lowers select after the acknowledge. The bench's host task drives every access this way on falling edges. It waits for the acknowledge before it releases select, and it leaves idle cycles between accesses. Random operations and lengths therefore stay within that protocol, and the directed cases (latch overwrite, wide write without a pending byte, zero strobe length) cover the corners.

// File: rtl/rom_isa_pkg.sv
package rom_isa_pkg;
  typedef enum logic [2:0] {
    OP_NOP, OP_RD8, OP_RD16, OP_WR8, OP_WR16, OP_LOAD
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_STROBE, ST_HOLD, ST_DONE
  } st_e;
endpackage

// File: rtl/rom_isa_decode.sv
module rom_isa_decode
  import rom_isa_pkg::*;
#(
  parameter int HA_W     = 17,
  parameter int SIDE_BIT = 16,
  parameter int LOAD_BIT = 15,
  parameter int REG_LSB  = 9,
  parameter int REG_W    = 5,
  parameter int DAT_LSB  = 1,
  parameter int ISA_AW   = 10,
  parameter logic [ISA_AW-1:0] IO_BASE = 10'h300
) (
  input  logic [HA_W-1:0]   addr_i,
  input  logic              wide_i,
  input  logic              lat_valid_i,
  input  logic [7:0]        lat_byte_i,
  output op_e               op_o,
  output logic [ISA_AW-1:0] isa_addr_o,
  output logic [15:0]       wdata_o
);
  logic       side_b, load_win;
  logic [7:0] addr_byte;
  logic       unused_addr;

  assign side_b      = addr_i[SIDE_BIT];
  assign load_win    = addr_i[LOAD_BIT];
  assign addr_byte   = addr_i[DAT_LSB +: 8];
  assign unused_addr = ^addr_i;

  always_comb begin
    if (!side_b) begin
      if (load_win)    op_o = OP_LOAD;
      else if (wide_i) op_o = OP_RD16;
      else             op_o = OP_RD8;
    end else if (wide_i) begin
      op_o = lat_valid_i ? OP_WR16 : OP_NOP;
    end else begin
      op_o = OP_WR8;
    end
  end

  assign isa_addr_o = IO_BASE | ISA_AW'(addr_i[REG_LSB +: REG_W]);
  assign wdata_o    = (op_o == OP_WR16) ? {addr_byte, lat_byte_i} : {8'h00, addr_byte};
endmodule

// File: rtl/rom_isa_wlatch.sv
module rom_isa_wlatch (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [7:0] byte_i,
  input  logic       clear_i,
  output logic       valid_o,
  output logic [7:0] byte_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      byte_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      byte_o  <= byte_i;
    end else if (clear_i) begin
      valid_o <= 1'b0;
    end
  end

  a_r6_load_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> valid_o && byte_o == $past(byte_i));
  a_r7_clear_after_use: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i && !load_i |=> !valid_o);
endmodule

// File: rtl/rom_isa_seq.sv
module rom_isa_seq
  import rom_isa_pkg::*;
#(
  parameter int ISA_AW = 10,
  parameter int CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  op_e               op_i,
  input  logic [ISA_AW-1:0] addr_i,
  input  logic [15:0]       wdata_i,
  input  logic [CNT_W-1:0]  len_i,
  input  logic [15:0]       isa_rdata_i,
  output logic              ior_o,
  output logic              iow_o,
  output logic [ISA_AW-1:0] isa_addr_o,
  output logic [15:0]       isa_wdata_o,
  output logic              isa_data_oe_o,
  output logic              isa_wide_o,
  output logic              ack_o,
  output logic [15:0]       hdata_o,
  output logic              hdata_oe_o,
  output logic              load_o,
  output logic              consume_o
);
  st_e               st;
  op_e               op_q;
  logic [ISA_AW-1:0] addr_q;
  logic [15:0]       wdata_q, rdata_q;
  logic [CNT_W-1:0]  cnt;
  logic              is_rd, is_wr, busy;

  assign is_rd = (op_q == OP_RD8) || (op_q == OP_RD16);
  assign is_wr = (op_q == OP_WR8) || (op_q == OP_WR16);
  assign busy  = (st == ST_SETUP) || (st == ST_STROBE) || (st == ST_HOLD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st      <= ST_IDLE;
      op_q    <= OP_NOP;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      cnt     <= '0;
    end else begin
      case (st)
        ST_IDLE: if (sel_i) begin
          op_q    <= op_i;
          addr_q  <= addr_i;
          wdata_q <= wdata_i;
          cnt     <= (len_i == '0) ? '0 : len_i - CNT_W'(1);
          st      <= (op_i == OP_LOAD || op_i == OP_NOP) ? ST_DONE : ST_SETUP;
        end
        ST_SETUP: st <= ST_STROBE;
        ST_STROBE: begin
          if (cnt == '0) begin
            st <= ST_HOLD;
            if (is_rd)
              rdata_q <= (op_q == OP_RD16) ? isa_rdata_i : {isa_rdata_i[7:0], 8'h00};
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        ST_HOLD: st <= ST_DONE;
        ST_DONE: if (!sel_i) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign ior_o         = (st == ST_STROBE) && is_rd;
  assign iow_o         = (st == ST_STROBE) && is_wr;
  assign isa_addr_o    = addr_q;
  assign isa_wdata_o   = wdata_q;
  assign isa_data_oe_o = busy && is_wr;
  assign isa_wide_o    = busy && (op_q == OP_RD16 || op_q == OP_WR16);
  assign ack_o         = (st == ST_DONE);
  assign hdata_o       = rdata_q;
  assign hdata_oe_o    = (st == ST_DONE) && is_rd;
  assign load_o        = (st == ST_IDLE) && sel_i && (op_i == OP_LOAD);
  assign consume_o     = (st == ST_HOLD) && (op_q == OP_WR16);

  a_r11_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ior_o && iow_o));
  a_r11_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st == ST_IDLE |-> !ior_o && !iow_o && !ack_o);
  a_r9_setup_before: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ior_o || iow_o) |-> $stable(isa_addr_o) && $past(st == ST_SETUP));
  a_r9_hold_after: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ior_o || iow_o) |-> st == ST_HOLD && $stable(isa_addr_o));
  a_r9_ack_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o && sel_i |=> ack_o);
  a_r10_host_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdata_oe_o |-> ack_o && !isa_data_oe_o);
  a_r10_isa_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ior_o |-> !isa_data_oe_o);
endmodule

// File: rtl/rom_isa_bridge.sv
module rom_isa_bridge
  import rom_isa_pkg::*;
#(
  parameter int HA_W   = 17,
  parameter int ISA_AW = 10,
  parameter int CNT_W  = 4,
  parameter logic [ISA_AW-1:0] IO_BASE = 10'h300
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rom_sel_i,
  input  logic [HA_W-1:0]   rom_addr_i,
  input  logic              rom_wide_i,
  input  logic [CNT_W-1:0]  strobe_len_i,
  output logic [15:0]       rom_data_o,
  output logic              rom_data_oe_o,
  output logic              rom_ack_o,
  output logic [ISA_AW-1:0] isa_addr_o,
  output logic [15:0]       isa_data_o,
  input  logic [15:0]       isa_data_i,
  output logic              isa_data_oe_o,
  output logic              isa_wide_o,
  output logic              isa_ior_o,
  output logic              isa_iow_o
);
  localparam int SIDE_BIT = HA_W - 1;
  localparam int LOAD_BIT = HA_W - 2;

  op_e               dec_op;
  logic [ISA_AW-1:0] dec_addr;
  logic [15:0]       dec_wdata, wdata_q, hdata;
  logic              lat_valid, lat_load, lat_clear, hdata_oe;
  logic [7:0]        lat_byte;

  rom_isa_decode #(
    .HA_W(HA_W), .SIDE_BIT(SIDE_BIT), .LOAD_BIT(LOAD_BIT), .REG_LSB(9), .REG_W(5),
    .DAT_LSB(1), .ISA_AW(ISA_AW), .IO_BASE(IO_BASE)
  ) u_decode (
    .addr_i(rom_addr_i), .wide_i(rom_wide_i), .lat_valid_i(lat_valid),
    .lat_byte_i(lat_byte), .op_o(dec_op), .isa_addr_o(dec_addr), .wdata_o(dec_wdata)
  );

  rom_isa_wlatch u_wlatch (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(lat_load), .byte_i(rom_addr_i[8:1]),
    .clear_i(lat_clear), .valid_o(lat_valid), .byte_o(lat_byte)
  );

  rom_isa_seq #(.ISA_AW(ISA_AW), .CNT_W(CNT_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(rom_sel_i), .op_i(dec_op),
    .addr_i(dec_addr), .wdata_i(dec_wdata), .len_i(strobe_len_i),
    .isa_rdata_i(isa_data_i), .ior_o(isa_ior_o), .iow_o(isa_iow_o),
    .isa_addr_o(isa_addr_o), .isa_wdata_o(wdata_q), .isa_data_oe_o(isa_data_oe_o),
    .isa_wide_o(isa_wide_o), .ack_o(rom_ack_o), .hdata_o(hdata),
    .hdata_oe_o(hdata_oe), .load_o(lat_load), .consume_o(lat_clear)
  );

  assign rom_data_oe_o = hdata_oe;
  assign rom_data_o    = hdata_oe ? hdata : '0;
  assign isa_data_o    = isa_data_oe_o ? wdata_q : '0;
endmodule

// File: tb/rom_isa_bridge_tb.sv
module rom_isa_bridge_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        sel = 1'b0, wide = 1'b0;
  logic [16:0] addr = '0;
  logic [3:0]  slen = '0;
  logic [15:0] rom_data, isa_dout, isa_din;
  logic        rom_oe, ack, isa_oe, isa_wide, ior, iow;
  logic [9:0]  isa_addr;

  logic [15:0] mem [32];
  bit          lat_v;
  logic [7:0]  lat_b;
  int          checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign isa_din = mem[isa_addr[4:0]];

  rom_isa_bridge dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .rom_sel_i(sel), .rom_addr_i(addr), .rom_wide_i(wide),
    .strobe_len_i(slen), .rom_data_o(rom_data), .rom_data_oe_o(rom_oe), .rom_ack_o(ack),
    .isa_addr_o(isa_addr), .isa_data_o(isa_dout), .isa_data_i(isa_din),
    .isa_data_oe_o(isa_oe), .isa_wide_o(isa_wide), .isa_ior_o(ior), .isa_iow_o(iow)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int eff_len(input logic [3:0] l);
    return (l == 0) ? 1 : int'(l);
  endfunction

  // kind: 0 rd8, 1 rd16, 2 wr8, 3 load, 4 wide side-B write
  task automatic host_op(input int kind, input logic [4:0] rg, input logic [7:0] b, input logic [3:0] l);
    bit side, ld, w, do_rd, do_wr, exp_wide;
    logic [15:0] exp_w, exp_r, got_w;
    int lat, nrd, nwr, exp_lat, bad_addr, bad_oe, exp_n;
    side = (kind >= 2 && kind != 3);
    ld   = (kind == 3);
    w    = (kind == 1 || kind == 4);
    do_rd = (kind <= 1);
    do_wr = (kind == 2) || (kind == 4 && lat_v);
    exp_wide = (kind == 1) || (kind == 4);
    exp_w = (kind == 4) ? {b, lat_b} : {8'h00, b};
    exp_r = (kind == 1) ? mem[rg] : {mem[rg][7:0], 8'h00};
    exp_n = (do_rd || do_wr) ? eff_len(l) : 0;
    exp_lat = (do_rd || do_wr) ? eff_len(l) + 3 : 1;
    @(negedge clk);
    sel = 1'b1; wide = w; slen = l;
    addr = {side, ld, 1'b0, rg, b, 1'b0};
    lat = 0; nrd = 0; nwr = 0; bad_addr = 0; bad_oe = 0; got_w = '0;
    do begin
      @(negedge clk);
      lat++;
      if (ior) nrd++;
      if (iow) begin nwr++; got_w = isa_dout; end
      if ((ior || iow) && isa_addr != (10'h300 | {5'b0, rg})) bad_addr++;
      if ((ior || iow) && isa_wide != exp_wide) bad_addr++;
      if (isa_oe != (do_wr && !ack)) bad_oe++;
    end while (!ack && lat < 40);
    chk(lat == exp_lat, "R9 ack latency", lat, exp_lat);
    chk(nrd == (do_rd ? exp_n : 0), do_rd ? "R3 R4 read strobe count" : "R6 R8 no read strobe", nrd, do_rd ? exp_n : 0);
    chk(nwr == (do_wr ? exp_n : 0), do_wr ? "R5 R7 write strobe count" : "R6 R8 no write strobe", nwr, do_wr ? exp_n : 0);
    chk(bad_addr == 0, "R2 I/O address and width", bad_addr, 0);
    chk(bad_oe == 0, "R10 I/O data drive", bad_oe, 0);
    chk(rom_oe == do_rd, "R10 host drive at ack", rom_oe, do_rd);
    if (do_rd) chk(rom_data == exp_r, kind == 1 ? "R4 wide read data" : "R3 byte read data", rom_data, exp_r);
    else       chk(rom_data == 16'h0, "R10 host data idle", rom_data, 0);
    if (do_wr) chk(got_w == exp_w, kind == 4 ? "R7 wide write data" : "R5 byte write data", got_w, exp_w);
    @(negedge clk);
    chk(ack == 1'b1, "R9 ack held while selected", ack, 1);
    sel = 1'b0;
    @(negedge clk);
    chk(!ack && !rom_oe, "R9 ack drops after select", {ack, rom_oe}, 0);
    if (ld) begin lat_v = 1; lat_b = b; end
    if (do_wr) begin
      if (kind == 4) begin mem[rg] = exp_w; lat_v = 0; end
      else mem[rg][7:0] = b;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 32; i++) mem[i] = 16'(i * 16'h1357 + 16'h0a5c);
    lat_v = 0; lat_b = '0;
    repeat (3) @(negedge clk);
    chk(!ior && !iow && !ack && !rom_oe && !isa_oe, "R1 reset outputs", {ior, iow, ack, rom_oe, isa_oe}, 0);
    rst_ni = 1'b1;
    // R11: address toggling without select does nothing
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); addr = 17'($urandom); wide = 1'($urandom);
      @(negedge clk);
      chk(!ior && !iow && !ack, "R11 no activity without select", {ior, iow, ack}, 0);
    end
    // directed corners
    host_op(0, 5'd0, 8'h00, 4'd0);   // R3 zero length -> 1 cycle strobe
    host_op(1, 5'd31, 8'h00, 4'd15); // R4 long strobe, top register
    host_op(4, 5'd4, 8'h77, 4'd2);   // R8 wide write with nothing latched
    host_op(3, 5'd0, 8'h11, 4'd1);   // R6 load
    host_op(3, 5'd0, 8'h22, 4'd1);   // R6 overwrite
    host_op(2, 5'd6, 8'h99, 4'd1);   // R5 byte write leaves latch
    host_op(4, 5'd6, 8'hc3, 4'd3);   // R7 uses 0x22 as low byte
    host_op(1, 5'd6, 8'h00, 4'd1);   // R4 read back wide word
    host_op(4, 5'd6, 8'h5a, 4'd1);   // R8 latch consumed -> no write
    host_op(0, 5'd6, 8'h00, 4'd2);   // R3 read back
    for (int i = 0; i < 300; i++)
      host_op($urandom_range(0, 4), 5'($urandom), 8'($urandom), 4'($urandom_range(0, 6)));
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule